// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block sends words over a synchronous serial link on which the far end is the clock master. The shift clock arrives on an input pin, so the block contains no rate generator. The pin is brought into the system clock domain, and each shift happens on a detected edge of that clock. Data leaves on a single output, least significant bit first. A polarity bit chooses which external edge changes the output, so that the master can sample on the other edge.

A host writes words into a holding register. A separate shift register drives the bits out, so the two registers form a two-deep queue. When the shifter is idle, a written word passes straight to it. A word written while a frame is in flight waits in the holding register and moves across on the edge that retires the last bit of the current frame. An empty flag for the holding register can raise an interrupt request. A second status reports that the shifter has nothing left to send.

Frames are 8 or 9 bits long. In 9-bit mode the extra bit comes from a separate configuration bit, which is captured when the word is written. Transmission runs only while the port is enabled, synchronous mode is selected, the external clock source is selected, transmit is enabled and both receive enables are clear.

Top module: `sst_tx_slave`

## Requirements
- R1: While `cfg_port_en` or `cfg_tx_en` is low, both registers and the bit count are cleared. One cycle later `hold_empty`=1, `shift_empty`=1 and `tx_out`=1.
- R2: Handoff and shifting happen only while `cfg_port_en`=1, `cfg_sync_mode`=1, `cfg_clk_master`=0, `cfg_tx_en`=1, `cfg_rx_single`=0 and `cfg_rx_cont`=0. Otherwise `tx_out` holds its value, external edges are ignored and a written word stays in the holding register.
- R3: A word written while both registers are empty and transmission is allowed enters the shifter in the write cycle. From the next cycle `shift_empty`=0, `hold_empty` stays 1 and `tx_out` shows bit 0 of the word.
- R4: A word written while a frame is shifting stays in the holding register, and `hold_empty` stays 0 until that word moves on.
- R5: On the drive edge that retires the last bit of a frame, a waiting word moves to the shifter. `tx_out` then shows its bit 0 and `hold_empty` becomes 1.
- R6: Bits leave least significant first, one per drive edge of `ext_clk`. The drive edge is the falling edge when `cfg_pol`=0 and the rising edge when `cfg_pol`=1. An edge takes effect on the third system clock edge after the pin changes.
- R7: With `cfg_nine_bit`=1 at write time the frame is 9 bits long, and bit 8 of the frame is the value of `cfg_bit9` at write time.
- R8: `irq` is high exactly when `cfg_irq_en`=1 and `hold_empty`=1.
- R9: `shift_empty` is 1 whenever no frame is in progress. After the drive edge that follows the last bit, the line idles with `tx_out`=1.
- R10: A write while the holding register is full, and no handoff happens in that cycle, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_port_en | input | 1 | Serial port enable |
| cfg_sync_mode | input | 1 | Synchronous mode select |
| cfg_clk_master | input | 1 | Clock source: 1 internal (not served here), 0 external pin |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_single | input | 1 | Single receive enable; must be 0 to transmit |
| cfg_rx_cont | input | 1 | Continuous receive enable; must be 0 to transmit |
| cfg_pol | input | 1 | 0: drive on falling edge, 1: drive on rising edge |
| cfg_nine_bit | input | 1 | 9-bit frame select, captured at write |
| cfg_bit9 | input | 1 | Ninth data bit, captured at write |
| cfg_irq_en | input | 1 | Interrupt enable for the holding-empty flag |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data word to send |
| ext_clk | input | 1 | Shift clock from the external master |
| tx_out | output | 1 | Serial data output |
| hold_empty | output | 1 | Holding register empty |
| shift_empty | output | 1 | Shifter idle, no bits left |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default two-stage synchronizer and 8-bit data words. These values put the three-cycle edge latency and both the 8- and 9-bit frame lengths within reach. The external clock is toggled slowly, eight system cycles per phase, so every drive edge can be checked one bit at a time under both polarities. This also reaches the exact edge on which a waiting word takes over from a finished frame.

// File: rtl/sst_pkg.sv
package sst_pkg;

    parameter int unsigned SST_DATA_W    = 8;
    localparam int unsigned SST_FRAME_MAX = SST_DATA_W + 1;
    localparam int unsigned SST_CNT_W     = $clog2(SST_FRAME_MAX + 1);

    typedef logic [SST_CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic port_en;
        logic sync_mode;
        logic clk_master;
        logic tx_en;
        logic rx_single;
        logic rx_cont;
        logic pol;
    } cfg_t;

    typedef struct packed {
        logic                  nine;
        logic [SST_DATA_W:0]   bits;
    } word_t;

    function automatic logic cfg_enabled(cfg_t c);
        return c.port_en & c.tx_en;
    endfunction

    function automatic logic cfg_go(cfg_t c);
        return c.port_en & c.sync_mode & ~c.clk_master & c.tx_en
             & ~c.rx_single & ~c.rx_cont;
    endfunction

    function automatic cnt_t frame_len(logic nine);
        return nine ? cnt_t'(SST_FRAME_MAX) : cnt_t'(SST_DATA_W);
    endfunction

endpackage

// File: rtl/sst_sync.sv
module sst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) q[i] <= 1'b0;
                    else     q[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) q[i] <= 1'b0;
                    else     q[i] <= q[i-1];
                end
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/sst_edge.sv
module sst_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic pol,
    output logic drive_evt
);
    logic prev;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    always_comb begin
        rise      = lvl & ~prev;
        fall      = ~lvl & prev;
        drive_evt = pol ? rise : fall;
    end
endmodule

// File: rtl/sst_hold.sv
module sst_hold
    import sst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  load,
    input  word_t load_word,
    input  logic  take,
    output logic  full,
    output word_t word
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            full <= 1'b0;
            word <= '0;
        end else if (load) begin
            full <= 1'b1;
            word <= load_word;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/sst_shift.sv
module sst_shift
    import sst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  load,
    input  word_t load_word,
    input  logic  step,
    output logic  empty,
    output logic  last,
    output logic  tx_out
);
    logic [SST_DATA_W:0] sr;
    cnt_t                cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr     <= '0;
            cnt    <= '0;
            tx_out <= 1'b1;
        end else if (load) begin
            sr     <= load_word.bits;
            cnt    <= frame_len(load_word.nine);
            tx_out <= load_word.bits[0];
        end else if (step) begin
            if (cnt > cnt_t'(1)) begin
                sr     <= sr >> 1;
                cnt    <= cnt - cnt_t'(1);
                tx_out <= sr[1];
            end else if (cnt == cnt_t'(1)) begin
                cnt    <= '0;
                tx_out <= 1'b1;
            end
        end
    end

    assign empty = (cnt == '0);
    assign last  = (cnt == cnt_t'(1));
endmodule

// File: rtl/sst_tx_slave.sv
module sst_tx_slave
    import sst_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_port_en,
    input  logic                  cfg_sync_mode,
    input  logic                  cfg_clk_master,
    input  logic                  cfg_tx_en,
    input  logic                  cfg_rx_single,
    input  logic                  cfg_rx_cont,
    input  logic                  cfg_pol,
    input  logic                  cfg_nine_bit,
    input  logic                  cfg_bit9,
    input  logic                  cfg_irq_en,
    input  logic                  wr_valid,
    input  logic [SST_DATA_W-1:0] wr_data,
    input  logic                  ext_clk,
    output logic                  tx_out,
    output logic                  hold_empty,
    output logic                  shift_empty,
    output logic                  irq
);
    cfg_t  cfg;
    word_t wr_word, hold_word, sh_word;
    logic  ena, go;
    logic  clk_sync, drive_evt, step;
    logic  hold_full, sh_empty, sh_last, shift_free;
    logic  take_hold, take_wr, hold_load, sh_load;

    always_comb begin
        cfg = '{port_en:    cfg_port_en,
                sync_mode:  cfg_sync_mode,
                clk_master: cfg_clk_master,
                tx_en:      cfg_tx_en,
                rx_single:  cfg_rx_single,
                rx_cont:    cfg_rx_cont,
                pol:        cfg_pol};
        wr_word = '{nine: cfg_nine_bit, bits: {cfg_bit9, wr_data}};
        ena     = cfg_enabled(cfg);
        go      = cfg_go(cfg);
    end

    sst_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_clk),
        .dout (clk_sync)
    );

    sst_edge i_edge (
        .clk       (clk),
        .rst       (rst),
        .lvl       (clk_sync),
        .pol       (cfg.pol),
        .drive_evt (drive_evt)
    );

    always_comb begin
        step       = go & drive_evt;
        shift_free = sh_empty | (step & sh_last);
        take_hold  = go & hold_full & shift_free;
        take_wr    = go & ~hold_full & wr_valid & shift_free;
        hold_load  = ena & wr_valid & (~hold_full | take_hold) & ~take_wr;
        sh_load    = take_hold | take_wr;
        sh_word    = take_hold ? hold_word : wr_word;
    end

    sst_hold i_hold (
        .clk       (clk),
        .rst       (rst),
        .clear     (~ena),
        .load      (hold_load),
        .load_word (wr_word),
        .take      (take_hold),
        .full      (hold_full),
        .word      (hold_word)
    );

    sst_shift i_shift (
        .clk       (clk),
        .rst       (rst),
        .clear     (~ena),
        .load      (sh_load),
        .load_word (sh_word),
        .step      (step),
        .empty     (sh_empty),
        .last      (sh_last),
        .tx_out    (tx_out)
    );

    assign hold_empty  = ~hold_full;
    assign shift_empty = sh_empty;
    assign irq         = cfg_irq_en & ~hold_full;
endmodule

// File: rtl/sst_tx_checker.sv
module sst_tx_checker (
    input logic clk,
    input logic rst,
    input logic cfg_port_en,
    input logic cfg_sync_mode,
    input logic cfg_clk_master,
    input logic cfg_tx_en,
    input logic cfg_rx_single,
    input logic cfg_rx_cont,
    input logic wr_valid,
    input logic tx_out,
    input logic hold_empty,
    input logic shift_empty,
    input logic irq
);
    logic en_c, go_c;
    assign en_c = cfg_port_en & cfg_tx_en;
    assign go_c = en_c & cfg_sync_mode & ~cfg_clk_master & ~cfg_rx_single & ~cfg_rx_cont;

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en_c |=> hold_empty && shift_empty && tx_out); // R1

    AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (en_c && !go_c) |=> $stable(tx_out) && $stable(shift_empty)); // R2

    AST_DIRECT_START: assert property (@(posedge clk) disable iff (rst)
        (go_c && wr_valid && hold_empty && shift_empty) |=> !shift_empty && hold_empty); // R3

    AST_HANDOFF_FEEDS: assert property (@(posedge clk) disable iff (rst)
        (en_c && !hold_empty) ##1 hold_empty |-> !shift_empty); // R5

    AST_IRQ_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
        irq |-> hold_empty); // R8
endmodule

bind sst_tx_slave sst_tx_checker i_sst_tx_checker (
    .clk            (clk),
    .rst            (rst),
    .cfg_port_en    (cfg_port_en),
    .cfg_sync_mode  (cfg_sync_mode),
    .cfg_clk_master (cfg_clk_master),
    .cfg_tx_en      (cfg_tx_en),
    .cfg_rx_single  (cfg_rx_single),
    .cfg_rx_cont    (cfg_rx_cont),
    .wr_valid       (wr_valid),
    .tx_out         (tx_out),
    .hold_empty     (hold_empty),
    .shift_empty    (shift_empty),
    .irq            (irq)
);

// File: tb/test_sst_tx_slave.sv
module test_sst_tx_slave;
    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_port_en = 1'b0, cfg_sync_mode = 1'b0, cfg_clk_master = 1'b0;
    logic       cfg_tx_en = 1'b0, cfg_rx_single = 1'b0, cfg_rx_cont = 1'b0;
    logic       cfg_pol = 1'b0, cfg_nine_bit = 1'b0, cfg_bit9 = 1'b0, cfg_irq_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ext_clk = 1'b0;
    logic       tx_out, hold_empty, shift_empty, irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sst_tx_slave i_sst_tx_slave (
        .clk(clk), .rst(rst),
        .cfg_port_en(cfg_port_en), .cfg_sync_mode(cfg_sync_mode),
        .cfg_clk_master(cfg_clk_master), .cfg_tx_en(cfg_tx_en),
        .cfg_rx_single(cfg_rx_single), .cfg_rx_cont(cfg_rx_cont),
        .cfg_pol(cfg_pol), .cfg_nine_bit(cfg_nine_bit), .cfg_bit9(cfg_bit9),
        .cfg_irq_en(cfg_irq_en), .wr_valid(wr_valid), .wr_data(wr_data),
        .ext_clk(ext_clk), .tx_out(tx_out), .hold_empty(hold_empty),
        .shift_empty(shift_empty), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_word(input logic [7:0] d);
        @(negedge clk);
        wr_data  = d;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic half_phase();
        ext_clk = ~ext_clk;
        repeat (PHASE) @(negedge clk);
    endtask

    // one full external period: sample edge first, drive edge second
    task automatic ext_cycle();
        half_phase();
        half_phase();
    endtask

    task automatic walk_bits(input string req, input logic [8:0] w, input int n);
        for (int i = 1; i < n; i++) begin
            ext_cycle();
            chk(req, tx_out, w[i]);
        end
    endtask

    task automatic set_run(input logic pol);
        @(negedge clk);
        cfg_pol = pol; ext_clk = pol;
        cfg_port_en = 1; cfg_sync_mode = 1; cfg_clk_master = 0; cfg_tx_en = 1;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset hold_empty", hold_empty, 1);
        chk("R9 reset shift_empty", shift_empty, 1);
        chk("R1 reset tx_out", tx_out, 1);
        chk("R8 irq masked", irq, 0);
    endtask

    task automatic t_direct(input logic pol, input logic [7:0] d);
        set_run(pol);
        write_word(d);
        chk("R3 shift busy", shift_empty, 0);
        chk("R3 hold stays empty", hold_empty, 1);
        chk("R3 first bit", tx_out, d[0]);
        walk_bits("R6 lsb first", {1'b0, d}, 8);
        ext_cycle();
        chk("R9 idle after frame", shift_empty, 1);
        chk("R9 idle line", tx_out, 1);
    endtask

    task automatic t_two_words();
        set_run(0);
        cfg_irq_en = 1;
        write_word(8'h3C);
        write_word(8'h81);
        chk("R4 second word held", hold_empty, 0);
        chk("R8 irq low while full", irq, 0);
        walk_bits("R6 first word", {1'b0, 8'h3C}, 8);
        ext_cycle();
        chk("R5 handoff bit0", tx_out, 1'b1);
        chk("R5 hold empty after handoff", hold_empty, 1);
        chk("R5 still busy", shift_empty, 0);
        chk("R8 irq on empty", irq, 1);
        write_word(8'h5A);
        write_word(8'hFF);
        chk("R4 third word held", hold_empty, 0);
        walk_bits("R6 second word", {1'b0, 8'h81}, 8);
        ext_cycle();
        chk("R5 third word bit0", tx_out, 1'b0);
        chk("R10 dropped write", hold_empty, 1);
        walk_bits("R6 third word", {1'b0, 8'h5A}, 8);
        ext_cycle();
        chk("R10 nothing follows", shift_empty, 1);
        cfg_irq_en = 0;
    endtask

    task automatic t_nine();
        set_run(0);
        cfg_nine_bit = 1; cfg_bit9 = 1;
        write_word(8'h00);
        cfg_bit9 = 0; cfg_nine_bit = 0;
        chk("R7 bit0", tx_out, 0);
        walk_bits("R7 nine bit frame", 9'h100, 9);
        chk("R7 still busy after 9th bit", shift_empty, 0);
        ext_cycle();
        chk("R7 frame ends after 9", shift_empty, 1);
    endtask

    task automatic t_gating();
        set_run(0);
        cfg_rx_cont = 1;
        write_word(8'hA5);
        ext_cycle();
        chk("R2 blocked by receive", shift_empty, 1);
        chk("R2 word waits", hold_empty, 0);
        cfg_rx_cont = 0;
        @(negedge clk);
        chk("R2 starts when released", tx_out, 1);
        chk("R2 busy when released", shift_empty, 0);
        ext_cycle();
        chk("R6 bit1", tx_out, 0);
        cfg_clk_master = 1;
        ext_cycle();
        chk("R2 internal source freezes", tx_out, 0);
        cfg_clk_master = 0;
        ext_cycle();
        chk("R2 resumes bit2", tx_out, 1);
        for (int i = 3; i < 8; i++) begin
            ext_cycle();
            chk("R6 resumed bits", tx_out, 8'hA5 >> i & 1);
        end
        ext_cycle();
        chk("R9 gating frame done", shift_empty, 1);
    endtask

    task automatic t_disable();
        set_run(0);
        write_word(8'h0E);
        write_word(8'h77);
        ext_cycle();
        chk("R6 pre-disable bit", tx_out, 1);
        cfg_tx_en = 0;
        @(negedge clk);
        chk("R1 hold cleared", hold_empty, 1);
        chk("R1 shift cleared", shift_empty, 1);
        chk("R1 line idle", tx_out, 1);
        cfg_tx_en = 1;
        repeat (3) @(negedge clk);
        chk("R1 nothing resumes", shift_empty, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_direct(0, 8'hB2);
        t_direct(1, 8'h4D);
        t_two_words();
        t_nine();
        t_gating();
        t_disable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule